// File: doc/BRIEF.md
# SPI Transmit Word Queue with Serial-Clock Spacing

This block sits between a processor write port and the transmit shift register of an SPI controller. Written words go into a four-entry first-in first-out store. One word at a time moves from the store into a single holding register, and from there it is offered to the shifter with a one-cycle load pulse. The holding register is refilled only after the shifter reports that the last bit of the current word has gone out. A programmable number of serial-clock periods, counted on a tick input, can then be inserted before the next word moves forward. A gap of zero gives back-to-back words.

The block also reports how many words the store holds and raises a transmit interrupt whenever that count is at or below a trigger level. Queue mode is off after reset and is turned on by an enable input. A separate clear input empties the store without leaving queue mode. The shift register itself is outside this block.

Top module: `txq_gap_feeder`

## Requirements
- R1: While `rst` is high, and on every edge where `fifo_en` is 0, the block empties itself. `fill_cnt` goes to 0, `tx_irq` to 0 and `ld_req` to 0, and writes are ignored.
- R2: With queue mode on, each accepted write raises `fill_cnt` by one at the edge that samples `wr_en`, up to a maximum of 4.
- R3: A write sampled while `fill_cnt` is 4 is dropped. The count stays at 4 and the dropped word never appears on `ld_data`.
- R4: Words leave on `ld_data` in the order they were written. Each word is marked by `ld_req` being high for exactly one cycle, and `ld_data` holds the word from that cycle on.
- R5: After an `ld_req`, no further word enters the holding register, and no `ld_req` is raised, until `sh_done` has been sampled high. Until then `fill_cnt` does not fall.
- R6: Let the spacing value `gap_cycles` be G, sampled at the edge that samples `sh_done`. Ticks are counted at later edges where `sclk_tick` is high. The next word's `ld_req` rises exactly two edges after the edge that counts the G-th tick. When G is 0, it rises two edges after the `sh_done` edge. `sclk_tick` has no effect while a word is being shifted. G may be any value from 0 to 255.
- R7: `fill_cnt` falls by one at the edge where a word moves from the store into the holding register. That edge is one edge before the word's `ld_req` rises. A write into an empty, idle queue therefore gives `ld_req` two edges after the write.
- R8: While `ptr_clr` is high, `fill_cnt` becomes 0 and writes are dropped. Words that were stored are discarded and never sent. After `ptr_clr` falls, new writes are stored and sent normally.
- R9: `tx_irq` changes at the same edge as `fill_cnt`. It is 1 exactly when queue mode is on and the new `fill_cnt` is less than or equal to `trig_lvl` as sampled at that edge.
- R10: Clearing `fifo_en` also drops the holding register and any word in flight. After queue mode is turned back on, a new write is sent without waiting for `sh_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue mode enable |
| ptr_clr | input | 1 | Empties the store while high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to queue |
| gap_cycles | input | GW | Serial-clock periods between words |
| trig_lvl | input | log2(DEPTH)+1 | Interrupt trigger level |
| sclk_tick | input | 1 | One pulse per serial-clock period |
| sh_done | input | 1 | Shifter has sent the last bit |
| ld_req | output | 1 | One-cycle load pulse to the shifter |
| ld_data | output | DW | Word to load |
| fill_cnt | output | log2(DEPTH)+1 | Words held in the store |
| tx_irq | output | 1 | Count at or below trigger level |

## Verification
The checker assumes the shifter behaves: `sh_done` comes only once per loaded word, and never in the cycle `ld_req` is high. It also assumes `sclk_tick` is a single-cycle strobe. The bench plays the shifter itself, so it raises `sh_done` only after it has seen a load, and it drives ticks as one-cycle pulses. It sweeps every trigger level against every fill count. It walks the spacing value through several counts up to 255, with varied idle cycles between ticks.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BUSY = 2'd1,
    PH_GAP  = 2'd2
  } phase_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH):0]     cnt,
  output logic [$clog2(DEPTH):0]     cnt_nxt
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          accept, take;

  assign accept = push && !clr && (cnt != CW'(DEPTH));
  assign take   = pop  && !clr && (cnt != '0);
  assign rdata  = mem[rp];

  always_comb begin
    if (clr) cnt_nxt = '0;
    else     cnt_nxt = cnt + CW'(accept) - CW'(take);
  end

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + AW'(accept);
      rp  <= rp + AW'(take);
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/txq_pacer.sv
module txq_pacer
  import txq_pkg::*;
#(
  parameter int DW = 8,
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          src_empty,
  input  logic [DW-1:0] src_data,
  output logic          pop,
  input  logic [GW-1:0] gap_cycles,
  input  logic          tick,
  input  logic          last_done,
  output logic          ld_req,
  output logic [DW-1:0] ld_data
);
  phase_t        ph;
  logic          hb_v;
  logic [DW-1:0] hb_d;
  logic [GW-1:0] gcnt;

  // refill the holding register only once the shifter is done and the gap is over
  assign pop = en && (ph == PH_IDLE) && !hb_v && !src_empty;

  always_ff @(posedge clk) begin
    if (pop) hb_d <= src_data;
  end

  always_ff @(posedge clk) begin
    if (rst) ld_data <= '0;
    else if (en && (ph == PH_IDLE) && hb_v) ld_data <= hb_d;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph     <= PH_IDLE;
      hb_v   <= 1'b0;
      ld_req <= 1'b0;
      gcnt   <= '0;
    end else begin
      ld_req <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (hb_v) begin
            ld_req <= 1'b1;
            hb_v   <= 1'b0;
            ph     <= PH_BUSY;
          end else if (pop) begin
            hb_v <= 1'b1;
          end
        end
        PH_BUSY: begin
          if (last_done) begin
            if (gap_cycles == '0) begin
              ph <= PH_IDLE;
            end else begin
              gcnt <= gap_cycles;
              ph   <= PH_GAP;
            end
          end
        end
        PH_GAP: begin
          if (tick) begin
            if (gcnt == GW'(1)) ph <= PH_IDLE;
            gcnt <= gcnt - GW'(1);
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txq_gap_feeder.sv
module txq_gap_feeder #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int GW    = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fifo_en,
  input  logic                   ptr_clr,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data,
  input  logic [GW-1:0]          gap_cycles,
  input  logic [$clog2(DEPTH):0] trig_lvl,
  input  logic                   sclk_tick,
  input  logic                   sh_done,
  output logic                   ld_req,
  output logic [DW-1:0]          ld_data,
  output logic [$clog2(DEPTH):0] fill_cnt,
  output logic                   tx_irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          store_clr;
  logic          pop;
  logic [DW-1:0] head;
  logic [CW-1:0] cnt_nxt;

  assign store_clr = !fifo_en || ptr_clr;

  txq_store #(.DW(DW), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (store_clr),
    .push    (wr_en),
    .wdata   (wr_data),
    .pop     (pop),
    .rdata   (head),
    .cnt     (fill_cnt),
    .cnt_nxt (cnt_nxt)
  );

  txq_pacer #(.DW(DW), .GW(GW)) pacer_i (
    .clk        (clk),
    .rst        (rst),
    .en         (fifo_en),
    .src_empty  ((fill_cnt == '0) || ptr_clr),
    .src_data   (head),
    .pop        (pop),
    .gap_cycles (gap_cycles),
    .tick       (sclk_tick),
    .last_done  (sh_done),
    .ld_req     (ld_req),
    .ld_data    (ld_data)
  );

  // interrupt registered alongside the count so both move on the same edge
  always_ff @(posedge clk) begin
    if (rst) tx_irq <= 1'b0;
    else     tx_irq <= fifo_en && (cnt_nxt <= trig_lvl);
  end
endmodule

// File: rtl/txq_gap_feeder_chk.sv
module txq_gap_feeder_chk #(
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   fifo_en,
  input logic                   ptr_clr,
  input logic [$clog2(DEPTH):0] trig_lvl,
  input logic                   sh_done,
  input logic                   ld_req,
  input logic [$clog2(DEPTH):0] fill_cnt,
  input logic                   tx_irq
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic in_flight;

  always_ff @(posedge clk) begin
    if (rst || !fifo_en)        in_flight <= 1'b0;
    else if (ld_req && !sh_done) in_flight <= 1'b1;
    else if (sh_done)           in_flight <= 1'b0;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CW'(DEPTH)); // R2

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fifo_en && !ptr_clr && fill_cnt == CW'(DEPTH)) |=> (fill_cnt >= CW'(DEPTH - 1))); // R3

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    ld_req |=> !ld_req); // R4

  AST_NO_RELOAD_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    in_flight |-> !ld_req); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en || ptr_clr) |=> (fill_cnt == '0)); // R8

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tx_irq == ($past(fifo_en) && (fill_cnt <= $past(trig_lvl))))); // R9

  AST_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> (!ld_req && !tx_irq)); // R1
endmodule

bind txq_gap_feeder txq_gap_feeder_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/txq_gap_feeder_tb_top.sv
module txq_gap_feeder_tb_top;
  logic       clk = 1'b0;
  logic       rst, fifo_en, ptr_clr, wr_en, sclk_tick, sh_done;
  logic [7:0] wr_data, gap_cycles, ld_data;
  logic [2:0] trig_lvl, fill_cnt;
  logic       ld_req, tx_irq;
  int         errs = 0;
  int         checks = 0;

  always #5 clk = ~clk;

  txq_gap_feeder dut_i (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ptr_clr(ptr_clr),
    .wr_en(wr_en), .wr_data(wr_data), .gap_cycles(gap_cycles),
    .trig_lvl(trig_lvl), .sclk_tick(sclk_tick), .sh_done(sh_done),
    .ld_req(ld_req), .ld_data(ld_data), .fill_cnt(fill_cnt), .tx_irq(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    sh_done = 1'b1;
    cyc();
    sh_done = 1'b0;
  endtask

  // finish the current word, play `gap` ticks with `sp` idle cycles before each,
  // then expect the next word on the exact edge
  task automatic finish_word(input int gap, input int sp, input logic [7:0] exp, input int fb);
    bit early = 1'b0;
    gap_cycles = 8'(gap);
    done_pulse();
    for (int i = 0; i < gap; i++) begin
      for (int s = 0; s < sp; s++) begin
        cyc();
        if (ld_req) early = 1'b1;
      end
      sclk_tick = 1'b1;
      cyc();
      sclk_tick = 1'b0;
      if (ld_req) early = 1'b1;
    end
    chk(!early && !ld_req, "R6 no load before gap ends", int'(early | ld_req), 0);
    cyc();
    chk(fill_cnt == 3'(fb - 1), "R7 count drops one edge before load", fill_cnt, fb - 1);
    chk(!ld_req, "R6 load not yet", ld_req, 0);
    cyc();
    chk(ld_req == 1'b1, "R6 load on second edge", ld_req, 1);
    chk(ld_data == exp, "R4 write order", ld_data, exp);
    cyc();
    chk(!ld_req, "R4 one-cycle pulse", ld_req, 0);
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (ld_req) seen = 1'b1;
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; fifo_en = 1'b0; ptr_clr = 1'b0; wr_en = 1'b0; wr_data = '0;
    gap_cycles = '0; trig_lvl = '0; sclk_tick = 1'b0; sh_done = 1'b0;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    chk(fill_cnt == 0, "R1 reset count", fill_cnt, 0);
    chk(!tx_irq, "R1 reset irq", tx_irq, 0);
    chk(!ld_req, "R1 reset load", ld_req, 0);

    // writes while queue mode is off are ignored
    push(8'h11); push(8'h12); cyc();
    chk(fill_cnt == 0, "R1 disabled writes ignored", fill_cnt, 0);
    chk(!tx_irq, "R1 disabled irq low", tx_irq, 0);
    quiet(3, "R1 disabled no load");

    fifo_en = 1'b1;
    cyc();
    chk(tx_irq, "R9 empty at level 0", tx_irq, 1);
    push(8'hA0);
    chk(fill_cnt == 1, "R2 write counted", fill_cnt, 1);
    chk(!tx_irq, "R9 one above level 0", tx_irq, 0);
    cyc();
    chk(fill_cnt == 0, "R7 moved to holding", fill_cnt, 0);
    cyc();
    chk(ld_req && ld_data == 8'hA0, "R7 load two edges after write", ld_data, 8'hA0);

    // ticks while shifting are ignored
    sclk_tick = 1'b1; repeat (3) cyc(); sclk_tick = 1'b0;

    // every fill level against every trigger level, word in flight
    for (int n = 0; n <= 4; n++) begin
      if (n > 0) push(8'hA0 + 8'(n));
      for (int t = 0; t <= 4; t++) begin
        trig_lvl = 3'(t);
        cyc();
        chk(tx_irq == (n <= t), $sformatf("R9 fill %0d level %0d", n, t), tx_irq, int'(n <= t));
      end
      chk(fill_cnt == 3'(n), "R5 count holds while shifting", fill_cnt, n);
    end

    push(8'hEE); push(8'hEF);
    chk(fill_cnt == 4, "R3 full write dropped", fill_cnt, 4);
    chk(!ld_req, "R5 no refill before done", ld_req, 0);

    finish_word(0, 0, 8'hA1, 4);
    finish_word(1, 2, 8'hA2, 3);
    finish_word(3, 1, 8'hA3, 2);
    finish_word(5, 0, 8'hA4, 1);
    gap_cycles = 8'd0;
    done_pulse();
    quiet(6, "R3 dropped words never sent");
    chk(fill_cnt == 0, "R2 drained", fill_cnt, 0);

    // largest spacing
    push(8'hB0); cyc(); cyc();
    chk(ld_req && ld_data == 8'hB0, "R7 idle write to load", ld_data, 8'hB0);
    push(8'hB1);
    finish_word(255, 0, 8'hB1, 1);

    // pointer clear
    gap_cycles = 8'd0;
    push(8'hC0); push(8'hC1); push(8'hC2);
    chk(fill_cnt == 3, "R2 three queued", fill_cnt, 3);
    ptr_clr = 1'b1; wr_en = 1'b1; wr_data = 8'hC3;
    cyc();
    wr_en = 1'b0;
    chk(fill_cnt == 0, "R8 clear empties", fill_cnt, 0);
    cyc();
    chk(fill_cnt == 0, "R8 write during clear dropped", fill_cnt, 0);
    ptr_clr = 1'b0;
    push(8'hC4);
    chk(fill_cnt == 1, "R8 resumes after clear", fill_cnt, 1);
    finish_word(0, 0, 8'hC4, 1);
    done_pulse();
    quiet(4, "R8 cleared words never sent");

    // queue mode switched off mid-flight
    push(8'hD0); cyc(); cyc();
    chk(ld_req && ld_data == 8'hD0, "R4 word D0", ld_data, 8'hD0);
    push(8'hD1); push(8'hD2);
    chk(fill_cnt == 2, "R2 two queued", fill_cnt, 2);
    fifo_en = 1'b0;
    cyc();
    chk(fill_cnt == 0, "R10 disable empties", fill_cnt, 0);
    chk(!tx_irq, "R1 disable drops irq", tx_irq, 0);
    fifo_en = 1'b1;
    quiet(4, "R10 nothing left after disable");
    push(8'hD3); cyc(); cyc();
    chk(ld_req && ld_data == 8'hD3, "R10 no done needed after re-enable", ld_data, 8'hD3);

    cyc();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule